// File: doc/BRIEF.md
# Static-memory core emulation access sequencer

This block lets a fast static word memory stand in for a destructive-read core store behind an asynchronous read-then-write bus. The host frames each storage cycle with a use level, a read strobe for the first half and a write strobe for the second half. The block turns these into chip enable, output enable and write strobe for the memory. It also produces the active-low sense pulses the host expects, and an enable for the driver that puts the host's buffer word onto the memory data pins.

All timing is counted on a free-running fast clock. A rising edge of either strobe, once synchronized, starts a timer. After a fixed wait the timer fires one short pulse. A read pulse pulls low the sense line of every 1 bit in the stored word. A write pulse writes the 18-bit buffer word (16 data bits plus two parity bits) into the addressed location. The select strobe carries no information for this memory and is treated as always true.

Top module: `mem_strobe_seq`

## Requirements
- R1: `mem_ce_n_o` goes low one clock after `stor_use_i` and `supply_ok_i` are both sampled high, and high one clock after either is sampled low. `stor_sel_i` has no effect on any output.
- R2: While `rst` is high, `mem_ce_n_o`, `mem_oe_n_o` and `mem_we_n_o` are 1, `wr_drv_en_o` is 0 and all `sense_n_o` bits are 1.
- R3: A read strobe rising edge first sampled at clock edge t makes `sense_n_o` show the inverted stored word after edges t+DELAY_CYC+3 through t+DELAY_CYC+PULSE_CYC+2. Bit i of `sense_n_o` carries word bit i, and bits 17:16 are the two parity bits.
- R4: A sense line whose stored bit is 0 stays high, and all sense lines are high outside the read pulse window.
- R5: `mem_oe_n_o` is low after edge e exactly when the read strobe was high and the write strobe low at edge e-2, access is enabled at e, and no write pulse is being driven.
- R6: A write strobe rising edge first sampled at edge t drives `mem_we_n_o` low and `wr_drv_en_o` high after edges t+DELAY_CYC+3 through t+DELAY_CYC+PULSE_CYC+2.
- R7: Timers start only on rising edges. A strobe held high for any length of time produces one pulse, and a strobe already high while reset is released produces none.
- R8: The address and write word are captured at edge t+DELAY_CYC+2 and held on `mem_addr_o` and `mem_wr_o` for the whole write pulse, whatever the inputs do meanwhile.
- R9: `mem_oe_n_o` low and `wr_drv_en_o` high never occur in the same cycle.
- R10: When use or supply is sampled low, any pending read or write timer is cancelled and no write pulse reaches the memory.
- R11: Both byte-lane enables `lane_en_n_o` are held low, so every access moves the full 18-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst | input | 1 | Synchronous active-high reset |
| stor_use_i | input | 1 | Host storage cycle request level |
| stor_sel_i | input | 1 | Host select strobe, treated as always true |
| rd_strobe_i | input | 1 | Asynchronous read-half strobe |
| wr_strobe_i | input | 1 | Asynchronous write-half strobe |
| addr_i | input | ADDR_W | Word address from the host address register |
| wr_word_i | input | DATA_W+PAR_W | Buffer register data and parity |
| supply_ok_i | input | 1 | Memory supply present flag |
| mem_rd_i | input | DATA_W+PAR_W | Data returned from the memory pins |
| mem_addr_o | output | ADDR_W | Address to the memory |
| mem_wr_o | output | DATA_W+PAR_W | Captured write word for the data driver |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| wr_drv_en_o | output | 1 | Tristate enable of the write data driver |
| lane_en_n_o | output | 2 | Byte-lane enables, held active |
| sense_n_o | output | DATA_W+PAR_W | Active-low sense pulse lines |

## Verification
The bench holds the write strobe high for hundreds of cycles, and also across a reset release. A design that fires on the level would write repeatedly or spuriously and corrupt the stored word. It changes the address and data in the middle of a write pulse: a design without capture would split the write or land it at the wrong word, which a later read-back exposes. It drops the supply while a write is pending and raises the write strobe while the read strobe is still high. A missing cancel would write with no power, and missing gating would turn output enable and the data driver on together.

// File: rtl/mem_seq_pkg.sv
package mem_seq_pkg;
  typedef enum logic [1:0] {
    TM_IDLE  = 2'd0,
    TM_WAIT  = 2'd1,
    TM_PULSE = 2'd2
  } tmr_state_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic s1, s2, s3;

  // Reset preloads the chain with the live level so a strobe already high
  // at reset release is not mistaken for a new edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= async_i;
      s2 <= async_i;
      s3 <= async_i;
    end else begin
      s1 <= async_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level_o = s2;
  assign rise_o  = s2 & ~s3;

  assert_single_rise_R7: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/phase_timer.sv
module phase_timer
  import mem_seq_pkg::*;
#(
  parameter int DELAY = 80,
  parameter int WIDTH = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic start_i,
  output logic pulse_o,
  output logic fire_o
);
  localparam int CMAX = (DELAY > WIDTH) ? DELAY : WIDTH;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] D_LAST = CW'(DELAY - 1);
  localparam logic [CW-1:0] W_LAST = CW'(WIDTH - 1);

  tmr_state_t     state;
  logic [CW-1:0]  cnt;

  assign fire_o  = (state == TM_WAIT) && (cnt == D_LAST) && en_i;
  assign pulse_o = (state == TM_PULSE);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      state <= TM_IDLE;
      cnt   <= '0;
    end else if (start_i) begin
      state <= TM_WAIT;
      cnt   <= '0;
    end else begin
      case (state)
        TM_WAIT: begin
          if (cnt == D_LAST) begin
            state <= TM_PULSE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TM_PULSE: begin
          if (cnt == W_LAST) begin
            state <= TM_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= TM_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
    (state == TM_PULSE) |-> (cnt <= W_LAST));

  assert_pulse_after_wait_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(state == TM_PULSE) |-> $past(state == TM_WAIT));
endmodule

// File: rtl/mem_strobe_seq.sv
module mem_strobe_seq #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 16,
  parameter int PAR_W     = 2,
  parameter int DELAY_CYC = 80,
  parameter int PULSE_CYC = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      stor_use_i,
  input  logic                      stor_sel_i,
  input  logic                      rd_strobe_i,
  input  logic                      wr_strobe_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W+PAR_W-1:0]   wr_word_i,
  input  logic                      supply_ok_i,
  input  logic [DATA_W+PAR_W-1:0]   mem_rd_i,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [DATA_W+PAR_W-1:0]   mem_wr_o,
  output logic                      mem_ce_n_o,
  output logic                      mem_oe_n_o,
  output logic                      mem_we_n_o,
  output logic                      wr_drv_en_o,
  output logic [1:0]                lane_en_n_o,
  output logic [DATA_W+PAR_W-1:0]   sense_n_o
);
  localparam int WORD_W = DATA_W + PAR_W;

  logic sel_held, en;
  logic rd_lvl, rd_rise, wr_lvl, wr_rise;
  logic rd_pulse, rd_fire, wr_pulse, wr_fire;

  // Select is a short pulse on the host side; the static memory ignores it.
  assign sel_held = stor_sel_i | 1'b1;
  assign en       = stor_use_i & supply_ok_i & sel_held;

  strobe_sync u_rd_sync (
    .clk(clk), .rst(rst), .async_i(rd_strobe_i),
    .level_o(rd_lvl), .rise_o(rd_rise)
  );
  strobe_sync u_wr_sync (
    .clk(clk), .rst(rst), .async_i(wr_strobe_i),
    .level_o(wr_lvl), .rise_o(wr_rise)
  );

  phase_timer #(.DELAY(DELAY_CYC), .WIDTH(PULSE_CYC)) u_rd_tmr (
    .clk(clk), .rst(rst), .en_i(en), .start_i(rd_rise),
    .pulse_o(rd_pulse), .fire_o(rd_fire)
  );
  phase_timer #(.DELAY(DELAY_CYC), .WIDTH(PULSE_CYC)) u_wr_tmr (
    .clk(clk), .rst(rst), .en_i(en), .start_i(wr_rise),
    .pulse_o(wr_pulse), .fire_o(wr_fire)
  );

  assign lane_en_n_o = 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n_o  <= 1'b1;
      mem_oe_n_o  <= 1'b1;
      mem_we_n_o  <= 1'b1;
      wr_drv_en_o <= 1'b0;
      sense_n_o   <= '1;
      mem_addr_o  <= '0;
      mem_wr_o    <= '0;
    end else begin
      mem_ce_n_o  <= ~en;
      mem_oe_n_o  <= ~(rd_lvl & ~wr_lvl & en & ~wr_pulse);
      mem_we_n_o  <= ~(wr_pulse & en);
      wr_drv_en_o <= wr_pulse & en;
      sense_n_o   <= ~({WORD_W{rd_pulse}} & mem_rd_i);
      if (!wr_pulse) mem_addr_o <= addr_i;
      if (wr_fire)   mem_wr_o   <= wr_word_i;
    end
  end

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n_o && wr_drv_en_o));

  assert_ce_follows_enable_R1: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n_o |-> $past(stor_use_i && supply_ok_i));

  assert_write_needs_ce_R10: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n_o |-> !mem_ce_n_o);

  assert_write_word_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n_o && $past(!mem_we_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_wr_o)));

  assert_sense_in_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (sense_n_o != '1) |-> $past(rd_pulse));

  assert_read_fire_unused_R3: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> rd_pulse);
endmodule

// File: tb/sim_mem_strobe_seq.sv
module sim_mem_strobe_seq;
  localparam int D  = 40;
  localparam int PW = 4;
  localparam int LO = D + 3;
  localparam int HI = D + 2 + PW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        use_r = 1'b1, sel_r = 1'b0, rd_r = 1'b0, wr_r = 1'b0, pwr_r = 1'b1;
  logic [12:0] addr_r = '0;
  logic [17:0] wdata_r = '0;
  logic [17:0] mem_rd;
  logic [12:0] mem_addr;
  logic [17:0] mem_wr;
  logic        ce_n, oe_n, we_n, drv;
  logic [1:0]  lanes;
  logic [17:0] sense_n;

  int checks = 0, fails = 0, cyc = 0;
  int wpulses = 0, ce_lows = 0, overlaps = 0;
  logic we_prev = 1'b1;
  logic cmp_on = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  mem_strobe_seq #(.DELAY_CYC(D), .PULSE_CYC(PW)) u0 (
    .clk(clk), .rst(rst), .stor_use_i(use_r), .stor_sel_i(sel_r),
    .rd_strobe_i(rd_r), .wr_strobe_i(wr_r), .addr_i(addr_r), .wr_word_i(wdata_r),
    .supply_ok_i(pwr_r), .mem_rd_i(mem_rd), .mem_addr_o(mem_addr), .mem_wr_o(mem_wr),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .wr_drv_en_o(drv),
    .lane_en_n_o(lanes), .sense_n_o(sense_n)
  );

  // Bench memory array (aliased on the low 8 address bits)
  logic [17:0] tbmem [256];
  initial for (int i = 0; i < 256; i++) tbmem[i] = '0;
  always @(posedge clk) if (!we_n && !ce_n) tbmem[mem_addr[7:0]] <= mem_wr;
  assign mem_rd = (!ce_n && !oe_n) ? tbmem[mem_addr[7:0]] : '1;

  // Behavioural reference model
  logic [17:0] mmem [256];
  initial for (int i = 0; i < 256; i++) mmem[i] = '0;
  int   r_age = 0, w_age = 0;
  logic r_run = 0, w_run = 0, r_act, w_act, en_m;
  logic rd_h1 = 0, rd_h2 = 0, wr_h1 = 0, wr_h2 = 0;
  logic e_ce_n = 1, e_oe_n = 1, e_we_n = 1, e_drv = 0;
  logic [17:0] e_sense = '1, lat_d = '0;

  always @(posedge clk) begin
    en_m = use_r & pwr_r;
    if (rst) begin
      r_run = 0; w_run = 0;
      e_ce_n = 1; e_oe_n = 1; e_we_n = 1; e_drv = 0; e_sense = '1;
    end else begin
      if (rd_r && !rd_h1) begin r_run = 1; r_age = 0; end else if (r_run) r_age++;
      if (wr_r && !wr_h1) begin w_run = 1; w_age = 0; end else if (w_run) w_age++;
      if (!en_m) begin r_run = 0; w_run = 0; end
      if (r_run && r_age > HI) r_run = 0;
      if (w_run && w_age > HI) w_run = 0;
      if (w_run && w_age == D + 2) begin
        lat_d = wdata_r;
        mmem[addr_r[7:0]] = wdata_r;
      end
      r_act = r_run && r_age >= LO && r_age <= HI;
      w_act = w_run && w_age >= LO && w_age <= HI;
      e_ce_n  = !en_m;
      e_drv   = w_act;
      e_we_n  = !w_act;
      e_oe_n  = !(rd_h2 && !wr_h2 && en_m && !w_act);
      e_sense = r_act ? ~mmem[addr_r[7:0]] : '1;
    end
    rd_h2 = rd_h1; rd_h1 = rd_r;
    wr_h2 = wr_h1; wr_h1 = wr_r;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && cmp_on && !done) begin
      chk(ce_n === e_ce_n, "R1 chip enable", {31'b0, ce_n}, {31'b0, e_ce_n});
      chk(oe_n === e_oe_n, "R5 output enable", {31'b0, oe_n}, {31'b0, e_oe_n});
      chk(we_n === e_we_n && drv === e_drv, "R6 write strobe/driver",
          {30'b0, we_n, drv}, {30'b0, e_we_n, e_drv});
      chk(sense_n === e_sense, "R3 sense lines", {14'b0, sense_n}, {14'b0, e_sense});
      chk(lanes === 2'b00, "R11 lane enables", {30'b0, lanes}, 32'h0);
      if (e_drv) chk(mem_wr === lat_d, "R8 write word", {14'b0, mem_wr}, {14'b0, lat_d});
    end
    if (!rst) begin
      if (!we_n && we_prev) wpulses++;
      if (!ce_n) ce_lows++;
      if (!oe_n && drv) overlaps++;
    end
    we_prev = we_n;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL R2 watchdog expired actual %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  // One host storage cycle: read half, then write half; returns sensed word
  task automatic host_cycle(input logic [12:0] a, input logic [17:0] wd,
                            output logic [17:0] got);
    logic [17:0] acc = '1;
    addr_r = a; wdata_r = wd; rd_r = 1;
    repeat (90) begin @(negedge clk); acc &= sense_n; end
    rd_r = 0;
    repeat (10) begin @(negedge clk); acc &= sense_n; end
    wr_r = 1;
    repeat (90) @(negedge clk);
    wr_r = 0;
    repeat (10) @(negedge clk);
    got = ~acc;
  endtask

  initial begin
    logic [17:0] got;
    int base;
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n && !drv && sense_n == '1, "R2 reset state",
        {26'b0, ce_n, oe_n, we_n, drv, 2'b0}, {26'b0, 4'b1110, 2'b0});
    rst = 0; cmp_on = 1;
    repeat (5) @(negedge clk);

    host_cycle(13'd5, 18'h2A5C3, got);
    chk(got == 18'h0, "R4 blank word senses nothing", {14'b0, got}, 32'h0);
    host_cycle(13'd5, 18'h0F0F0, got);
    chk(got == 18'h2A5C3, "R3 R11 word with parity read back", {14'b0, got}, 32'h2A5C3);
    host_cycle(13'd8191, 18'h3FFFF, got);
    chk(got == 18'h0, "R4 top address blank", {14'b0, got}, 32'h0);
    host_cycle(13'd8191, 18'h00000, got);
    chk(got == 18'h3FFFF, "R3 all ones at top address", {14'b0, got}, 32'h3FFFF);
    host_cycle(13'd5, 18'h0F0F0, got);
    chk(got == 18'h0F0F0, "R3 alternating nibbles", {14'b0, got}, 32'h0F0F0);

    // R8: inputs change during the write pulse
    addr_r = 13'd40; wdata_r = 18'h15555; rd_r = 1;
    repeat (90) @(negedge clk);
    rd_r = 0; repeat (10) @(negedge clk);
    wr_r = 1;
    repeat (45) @(negedge clk);
    addr_r = 13'd41; wdata_r = 18'h0AAAA;
    repeat (45) @(negedge clk);
    wr_r = 0; repeat (10) @(negedge clk);
    host_cycle(13'd40, 18'h0, got);
    chk(got == 18'h15555, "R8 captured word kept", {14'b0, got}, 32'h15555);
    host_cycle(13'd41, 18'h0, got);
    chk(got == 18'h0, "R8 late address untouched", {14'b0, got}, 32'h0);

    // R7: write strobe held high while the host clock is stopped
    base = wpulses;
    addr_r = 13'd9; wdata_r = 18'h12345; rd_r = 1;
    repeat (90) @(negedge clk);
    rd_r = 0; repeat (10) @(negedge clk);
    wr_r = 1; repeat (400) @(negedge clk);
    wr_r = 0; repeat (10) @(negedge clk);
    chk(wpulses - base == 1, "R7 one pulse for held strobe", wpulses - base, 1);
    host_cycle(13'd9, 18'h0, got);
    chk(got == 18'h12345, "R7 held write stored once", {14'b0, got}, 32'h12345);

    // R7: strobe already high across reset release
    base = wpulses;
    wr_r = 1; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (200) @(negedge clk);
    chk(wpulses - base == 0, "R7 no pulse from level at reset", wpulses - base, 0);
    wr_r = 0; repeat (10) @(negedge clk);

    // R10: supply lost while a write is pending
    base = wpulses;
    addr_r = 13'd9; wdata_r = 18'h3C3C3; rd_r = 1;
    repeat (90) @(negedge clk);
    rd_r = 0; repeat (10) @(negedge clk);
    wr_r = 1; repeat (10) @(negedge clk);
    pwr_r = 0; repeat (80) @(negedge clk);
    pwr_r = 1; repeat (20) @(negedge clk);
    wr_r = 0; repeat (10) @(negedge clk);
    chk(wpulses - base == 0, "R10 no write without supply", wpulses - base, 0);
    host_cycle(13'd9, 18'h0, got);
    chk(got == 18'h0, "R10 memory unchanged after supply loss", {14'b0, got}, 32'h0);

    // R1/R10: use low suppresses the whole cycle
    base = wpulses;
    use_r = 0; repeat (3) @(negedge clk);
    ce_lows = 0;
    host_cycle(13'd20, 18'h3FFFF, got);
    chk(ce_lows == 0, "R1 chip enable idle without use", ce_lows, 0);
    chk(wpulses - base == 0, "R10 no write without use", wpulses - base, 0);
    chk(got == 18'h0, "R10 no sense without use", {14'b0, got}, 32'h0);
    use_r = 1; repeat (5) @(negedge clk);
    host_cycle(13'd20, 18'h0, got);
    chk(got == 18'h0, "R10 word left unwritten", {14'b0, got}, 32'h0);

    // R9/R1: write strobe rises while read strobe still high, select toggling
    addr_r = 13'd30; wdata_r = 18'h2DEAD; rd_r = 1;
    for (int i = 0; i < 50; i++) begin @(negedge clk); sel_r = ~sel_r; end
    wr_r = 1;
    for (int i = 0; i < 50; i++) begin @(negedge clk); sel_r = ~sel_r; end
    rd_r = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); sel_r = ~sel_r; end
    wr_r = 0; repeat (10) @(negedge clk);
    host_cycle(13'd30, 18'h0, got);
    chk(got == 18'h2DEAD, "R1 select ignored, overlap write stored", {14'b0, got}, 32'h2DEAD);
    chk(overlaps == 0, "R9 output enable and driver exclusive", overlaps, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule